// File: doc/BRIEF.md
# Serial Character Receiver with Flush on Disable

This block turns an asynchronous serial line into characters of five to nine data bits and holds the most recent one in a single-entry buffer until it is read. Each frame is one low start bit, the data bits with the least significant first, and one stop bit. A bit lasts `CLKS_PER_BIT` clock cycles. The line goes through a synchronizer and each bit is sampled near its middle. The buffer exposes the low eight data bits, the ninth bit, a receive-complete flag, and two error flags: one for a bad stop bit and one for a lost character.

Software reads the ninth bit and the flags first. It then pulses the low-byte read strobe, which frees the entry. The flags and the ninth bit still describe that entry until a new character arrives. While the enable input is low the receiver ignores the line and stays idle. Dropping the enable discards any buffered character and clears every flag.

Top module: `uart_rx_flush`

## Requirements
- R1: A synchronous reset clears `rx_full`, `err_frame`, `err_overrun`, `dout_b8` and `dout_lo`.
- R2: `size_code` selects the data bits per frame: 000 gives 5, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. The codes 100, 101 and 110 give 8. The received value is right-aligned: bit 0 is the first data bit received, `dout_lo` holds bits 7..0 and `dout_b8` holds bit 8. Unused upper bits read as 0.
- R3: A start is accepted only if the line is still low half a bit after a falling edge. A low pulse shorter than that produces no character.
- R4: A stop bit sampled low sets `err_frame` together with the character it ends. The data of that character is still delivered.
- R5: If a character completes while `rx_full` is high and no read is in progress, the new character is discarded and `err_overrun` goes high. The held data and ninth bit are unchanged.
- R6: A one-cycle pulse on `rd_lo` while `rx_full` is high clears `rx_full` on the next cycle. `dout_lo`, `dout_b8` and both error flags keep the values of the entry just read.
- R7: Driving `rx_en` low clears `rx_full`, `err_frame`, `err_overrun`, `dout_lo` and `dout_b8` on the next cycle.
- R8: While `rx_en` is low, activity on `rx_line` produces no character, including after the receiver is enabled again.
- R9: Loading a new character replaces the error flags with those of that character. This clears a previous `err_overrun` and a previous `err_frame`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receiver enable. Low flushes the buffer and idles the receiver |
| size_code | input | 3 | Character size code |
| rx_line | input | 1 | Serial input line, idle high |
| rd_lo | input | 1 | One-cycle strobe that reads the low byte and frees the entry |
| dout_lo | output | 8 | Low eight data bits of the buffered character |
| dout_b8 | output | 1 | Ninth data bit of the buffered character |
| rx_full | output | 1 | Buffer holds an unread character |
| err_frame | output | 1 | Stop bit of the buffered character was low |
| err_overrun | output | 1 | A character was lost while the buffer was full |

## Verification
The assertions assume that `size_code` changes only while `rx_en` is low. They also assume that `rd_lo` is a single-cycle strobe, so the hold property sees a full buffer with no read pending. The bench drives frames at exactly `CLKS_PER_BIT` cycles per bit. It changes the size code only inside a disable window and always returns the line high for a full bit time between frames. The glitch test keeps its low pulse well under half a bit.

// File: rtl/urx_pkg.sv
package urx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  localparam int unsigned MAX_BITS = 9;

  function automatic logic [3:0] bits_for_code(input logic [2:0] code);
    case (code)
      3'b000:  return 4'd5;
      3'b001:  return 4'd6;
      3'b010:  return 4'd7;
      3'b111:  return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst || !en) sr <= '1;
    else            sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/urx_bitrx.sv
module urx_bitrx
  import urx_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       line,
  input  logic [3:0] nbits,
  output logic       done,
  output logic [8:0] word,
  output logic       ferr,
  output logic       busy
);
  localparam int unsigned CW   = $clog2(CLKS_PER_BIT);
  localparam int unsigned HALF = CLKS_PER_BIT / 2;
  localparam logic [CW-1:0] FULL_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);

  rx_state_e            state;
  logic [CW-1:0]        cnt;
  logic [3:0]           idx;
  logic [MAX_BITS-1:0]  sh;
  logic                 prev;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      sh    <= '0;
      prev  <= 1'b1;
      done  <= 1'b0;
      word  <= '0;
      ferr  <= 1'b0;
    end else begin
      done <= 1'b0;
      prev <= line;
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (prev && !line) state <= ST_START;
        end
        ST_START: begin
          if (cnt == HALF_LAST) begin
            cnt <= '0;
            idx <= '0;
            state <= line ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == FULL_LAST) begin
            cnt <= '0;
            sh  <= {line, sh[MAX_BITS-1:1]};
            if (idx == 4'(nbits - 4'd1)) state <= ST_STOP;
            else                         idx   <= idx + 4'd1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == FULL_LAST) begin
            cnt   <= '0;
            state <= ST_IDLE;
            done  <= 1'b1;
            ferr  <= !line;
            word  <= sh >> (4'd9 - nbits);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/urx_holdbuf.sv
module urx_holdbuf (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       load,
  input  logic [8:0] word,
  input  logic       ferr_in,
  input  logic       rd,
  output logic [7:0] lo,
  output logic       b8,
  output logic       full,
  output logic       ferr,
  output logic       ovr
);
  logic room;
  assign room = !full || rd;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      lo   <= '0;
      b8   <= 1'b0;
      full <= 1'b0;
      ferr <= 1'b0;
      ovr  <= 1'b0;
    end else if (load && room) begin
      lo   <= word[7:0];
      b8   <= word[8];
      ferr <= ferr_in;
      ovr  <= 1'b0;
      full <= 1'b1;
    end else begin
      if (rd)   full <= 1'b0;
      if (load) ovr  <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_flush.sv
module uart_rx_flush #(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_en,
  input  logic [2:0] size_code,
  input  logic       rx_line,
  input  logic       rd_lo,
  output logic [7:0] dout_lo,
  output logic       dout_b8,
  output logic       rx_full,
  output logic       err_frame,
  output logic       err_overrun
);
  logic       line_s;
  logic [3:0] nbits;
  logic       rx_done;
  logic [8:0] rx_word;
  logic       rx_ferr;
  logic       rx_busy;

  assign nbits = urx_pkg::bits_for_code(size_code);

  urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .en(rx_en), .din(rx_line), .dout(line_s)
  );

  urx_bitrx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_bits (
    .clk(clk), .rst(rst), .en(rx_en), .line(line_s), .nbits(nbits),
    .done(rx_done), .word(rx_word), .ferr(rx_ferr), .busy(rx_busy)
  );

  urx_holdbuf u_buf (
    .clk(clk), .rst(rst), .en(rx_en), .load(rx_done), .word(rx_word),
    .ferr_in(rx_ferr), .rd(rd_lo), .lo(dout_lo), .b8(dout_b8),
    .full(rx_full), .ferr(err_frame), .ovr(err_overrun)
  );
endmodule

// File: rtl/uart_rx_flush_chk.sv
module uart_rx_flush_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_en,
  input logic       rd_lo,
  input logic [7:0] dout_lo,
  input logic       dout_b8,
  input logic       rx_full,
  input logic       err_frame,
  input logic       err_overrun,
  input logic       done,
  input logic       busy
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!rx_full && !err_frame && !err_overrun && dout_lo == 8'h00 && !dout_b8));

  a_r7_flush: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!rx_full && !err_frame && !err_overrun && dout_lo == 8'h00 && !dout_b8));

  a_r8_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!busy && !done));

  a_r6_read_frees: assert property (@(posedge clk) disable iff (rst)
    (rx_en && rx_full && rd_lo && !done) |=> !rx_full);

  a_r5_hold_entry: assert property (@(posedge clk) disable iff (rst)
    (rx_en && rx_full && !rd_lo) |=>
      (rx_full && $stable(dout_lo) && $stable(dout_b8) && $stable(err_frame)));

  a_r5_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (rx_en && rx_full && !rd_lo && done) |=> err_overrun);
endmodule

bind uart_rx_flush uart_rx_flush_chk u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .rd_lo(rd_lo), .dout_lo(dout_lo),
  .dout_b8(dout_b8), .rx_full(rx_full), .err_frame(err_frame),
  .err_overrun(err_overrun), .done(rx_done), .busy(rx_busy)
);

// File: tb/sim_uart_rx_flush.sv
`timescale 1ns/1ps
module sim_uart_rx_flush;
  localparam int CPB = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0;
  logic [2:0] size_code = 3'b011;
  logic       rx_line = 1'b1;
  logic       rd_lo = 1'b0;
  logic [7:0] dout_lo;
  logic       dout_b8, rx_full, err_frame, err_overrun;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  uart_rx_flush #(.CLKS_PER_BIT(CPB), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .rx_en(rx_en), .size_code(size_code),
    .rx_line(rx_line), .rd_lo(rd_lo), .dout_lo(dout_lo), .dout_b8(dout_b8),
    .rx_full(rx_full), .err_frame(err_frame), .err_overrun(err_overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
      $finish;
    end
  end

  task automatic drive_bit(input logic b);
    rx_line = b;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] v, input int n, input logic stopb);
    drive_bit(1'b1);
    drive_bit(1'b0);
    for (int i = 0; i < n; i++) drive_bit(v[i]);
    drive_bit(stopb);
    if (!stopb) drive_bit(1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic set_size(input logic [2:0] code);
    rx_en = 1'b0;
    @(negedge clk);
    size_code = code;
    rx_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_lo();
    rd_lo = 1'b1;
    @(negedge clk);
    rd_lo = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 full", rx_full, 0);
    check("R1 data", dout_lo, 0);
    check("R1 ferr", err_frame, 0);
    check("R1 ovr", err_overrun, 0);
  endtask

  task automatic t_size(input logic [2:0] code, input int n, input logic [8:0] v);
    set_size(code);
    send_frame(v, n, 1'b1);
    check("R2 full", rx_full, 1);
    check("R2 low byte", dout_lo, v[7:0]);
    check("R2 ninth bit", dout_b8, v[8]);
    read_lo();
  endtask

  task automatic t_read();
    set_size(3'b011);
    send_frame(9'h0A5, 8, 1'b1);
    read_lo();
    check("R6 full cleared", rx_full, 0);
    check("R6 data kept", dout_lo, 8'hA5);
  endtask

  task automatic t_glitch();
    set_size(3'b011);
    rx_line = 1'b0;
    repeat (3) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * CPB) @(negedge clk);
    check("R3 glitch ignored", rx_full, 0);
    send_frame(9'h03C, 8, 1'b1);
    check("R3 next frame ok", dout_lo, 8'h3C);
    read_lo();
  endtask

  task automatic t_frame_err();
    send_frame(9'h05A, 8, 1'b0);
    check("R4 ferr", err_frame, 1);
    check("R4 data", dout_lo, 8'h5A);
    read_lo();
    send_frame(9'h0C6, 8, 1'b1);
    check("R9 ferr cleared", err_frame, 0);
    check("R9 data", dout_lo, 8'hC6);
    read_lo();
  endtask

  task automatic t_overrun();
    send_frame(9'h011, 8, 1'b1);
    send_frame(9'h022, 8, 1'b1);
    check("R5 held data", dout_lo, 8'h11);
    check("R5 ovr", err_overrun, 1);
    check("R5 full", rx_full, 1);
    read_lo();
    check("R6 ovr kept", err_overrun, 1);
    send_frame(9'h033, 8, 1'b1);
    check("R9 new data", dout_lo, 8'h33);
    check("R9 ovr cleared", err_overrun, 0);
  endtask

  task automatic t_flush();
    send_frame(9'h044, 8, 1'b0);
    check("R7 setup full", rx_full, 1);
    rx_en = 1'b0;
    @(negedge clk);
    check("R7 full flushed", rx_full, 0);
    check("R7 ferr flushed", err_frame, 0);
    check("R7 ovr flushed", err_overrun, 0);
    check("R7 data flushed", dout_lo, 0);
  endtask

  task automatic t_disabled();
    rx_en = 1'b0;
    @(negedge clk);
    send_frame(9'h077, 8, 1'b1);
    rx_en = 1'b1;
    repeat (3 * CPB) @(negedge clk);
    check("R8 no char", rx_full, 0);
    check("R8 data", dout_lo, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    rx_en = 1'b1;
    @(negedge clk);
    t_size(3'b000, 5, 9'h013);
    t_size(3'b001, 6, 9'h02A);
    t_size(3'b010, 7, 9'h055);
    t_size(3'b011, 8, 9'h0A5);
    t_size(3'b111, 9, 9'h1C3);
    t_size(3'b101, 8, 9'h0E1);
    t_read();
    t_glitch();
    t_frame_err();
    t_overrun();
    t_flush();
    t_disabled();
    summary();
    $finish;
  end
endmodule